// File: doc/BRIEF.md
# Disk Controller Command Packet Port

This block is the host-facing register interface of a disk controller card. The host writes an 8-byte command packet into a data port, one byte at a time. Before each byte it polls a busy flag. After the eighth byte the block runs a small internal command executor, raises an interrupt, and offers an 8-byte result packet. The host reads that packet back through the same data port.

A status port reports three things: busy, whether result bytes are still waiting, and a running count of accepted data writes. A channel-select port chooses one of three DMA channels, and the same setting picks which of three interrupt lines carries the interrupt. A class port reports a fixed device class together with the live interrupt flag. A dedicated read port acknowledges the interrupt, and a reset port clears the command machinery. The executor does not touch any media. It echoes the parameters of the transfer commands it recognises and rejects every other command code.

Each access lasts one clock cycle. A cycle with `bus_sel` high is a read when `bus_wr` is low and a write when it is high. Read data is combinational from the current address, and any side effect of a read takes place at the end of that cycle. Port offsets are:

| Offset | Port |
|---|---|
| 00h | status |
| 02h | data |
| 04h | acknowledge |
| 06h | channel select |
| 08h | reset |
| FEh | class |

Top module: `disk_cmd_port`

## Requirements
- R1: A read of offset 00h returns the status byte. Bit 0 is busy, bit 2 is set while result bytes remain, bits 7:4 hold the write counter, and all other bits are 0. After `rst` the status byte is 00h.
- R2: A data write (offset 02h) that arrives while busy is clear is accepted, and busy then stays set for BUSY_CYC cycles. A data write that arrives while busy is set is discarded: the counter does not move and the packet does not change.
- R3: The 4-bit write counter rises by one for every accepted data write and wraps from 15 to 0.
- R4: The eighth packet byte starts execution, which keeps busy set for EXEC_CYC cycles. In the cycle busy falls, the interrupt becomes pending and 8 result bytes become available.
- R5: Reads of the data port return the result bytes in packet order, and bit 2 of the status byte clears after the eighth one. A data read when no result is waiting returns 00h and has no effect.
- R6: Packet byte order is: command, spare, cylinder low, cylinder high, head, sector, count low, count high. For commands C0h, C1h, C2h and C9h the result is: the command, 80h, the cylinder plus one (little-endian), then the head, sector and count as received.
- R7: For commands F4h and F5h the result has the same form as in R6, except that the cylinder field reads 0000h whatever cylinder was supplied.
- R8: Any other command code yields the result 00h, 08h, 00h, 00h, 00h, 00h, 00h, 00h.
- R9: A data byte of FFh written as the first byte of a packet is counted, but it does not become part of the packet. The next byte is still taken as the command byte.
- R10: A read of offset 04h clears the pending interrupt. If an execution completes in the same cycle, the interrupt stays pending.
- R11: Writing 02h, 04h or 08h to offset 06h sets `dma_sel` to 001, 010 or 100 respectively. Writing any other value sets it to 000. `irq_out` equals `dma_sel` while an interrupt is pending and is 000 otherwise.
- R12: A read of offset FEh returns the device class 01h in bits 6:0 and the pending interrupt in bit 7.
- R13: A write to offset 08h clears the following: the write counter, the packet position, any execution in progress, the result bytes and the pending interrupt. It keeps the channel selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |
| dma_sel | output | 3 | One-hot selected DMA channel (1..3) |
| irq_out | output | 3 | Interrupt lines, one per channel |

## Verification
Two collisions are provoked. In the first, an acknowledge read is placed in exactly the cycle in which an execution finishes. The bench counts the EXEC_CYC cycles after the eighth write so that the read lands on that cycle, then judges the result by the class port: the interrupt bit must still be set. In the second, a reset-port write cuts a packet off part way through. The next full packet must then decode from byte zero and the channel selection must survive. A behavioural model compares the status, data and class reads and both output vectors on every cycle, so any cycle offset in busy or completion is seen at once.

// File: rtl/disk_pkt_pkg.sv
package disk_pkt_pkg;

    localparam int PKT_BYTES = 8;
    localparam int IDX_W     = $clog2(PKT_BYTES);
    localparam int RIDX_W    = $clog2(PKT_BYTES + 1);
    localparam int CNT_W     = 4;
    localparam int NUM_CH    = 3;

    localparam logic [7:0] OFS_STATUS = 8'h00;
    localparam logic [7:0] OFS_DATA   = 8'h02;
    localparam logic [7:0] OFS_ACK    = 8'h04;
    localparam logic [7:0] OFS_CHSEL  = 8'h06;
    localparam logic [7:0] OFS_RESET  = 8'h08;
    localparam logic [7:0] OFS_CLASS  = 8'hFE;

    localparam logic [6:0] DEV_CLASS   = 7'h01;
    localparam logic [7:0] RES_OK      = 8'h80;
    localparam logic [7:0] RES_BADCMD  = 8'h08;
    localparam logic [7:0] CMD_REGTEST = 8'hFF;

    typedef logic [PKT_BYTES-1:0][7:0] pkt_bytes_t;

    typedef enum logic [7:0] {
        OP_READ    = 8'hC0,
        OP_WRITE   = 8'hC1,
        OP_VERIFY  = 8'hC2,
        OP_WRCHK   = 8'hC9,
        OP_SYS_RD  = 8'hF4,
        OP_SYS_WR  = 8'hF5
    } op_e;

    function automatic pkt_bytes_t run_cmd(input pkt_bytes_t c);
        pkt_bytes_t r;
        logic [15:0] cyl;
        r   = '0;
        cyl = {c[3], c[2]};
        case (c[0])
            OP_READ, OP_WRITE, OP_VERIFY, OP_WRCHK: begin
                r    = c;
                r[1] = RES_OK;
                cyl  = cyl + 16'd1;
                r[2] = cyl[7:0];
                r[3] = cyl[15:8];
            end
            OP_SYS_RD, OP_SYS_WR: begin
                r    = c;
                r[1] = RES_OK;
                r[2] = 8'h00;
                r[3] = 8'h00;
            end
            default: r[1] = RES_BADCMD;
        endcase
        return r;
    endfunction

    function automatic logic [NUM_CH-1:0] chan_decode(input logic [7:0] v);
        logic [NUM_CH-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (v == 8'(1 << (i + 1))) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] status_byte(input logic busy, input logic pend,
                                               input logic [CNT_W-1:0] cnt);
        return {cnt, 1'b0, pend, 1'b0, busy};
    endfunction

endpackage

// File: rtl/pkt_collect.sv
module pkt_collect
    import disk_pkt_pkg::*;
#(
    parameter int BUSY_CYC = 3,
    parameter int EXEC_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_stb,
    input  logic [7:0]       wdata,
    output logic             busy,
    output logic [CNT_W-1:0] wr_count,
    output logic             done,
    output pkt_bytes_t       pkt
);
    localparam int MAXC = (BUSY_CYC > EXEC_CYC) ? BUSY_CYC : EXEC_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0]    tmr;
    logic             exec_q;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic             skip;

    assign busy   = (tmr != '0);
    assign done   = exec_q && (tmr == TW'(1));
    assign accept = wr_stb && !busy;
    assign skip   = (idx == '0) && (wdata == CMD_REGTEST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tmr      <= '0;
            exec_q   <= 1'b0;
            idx      <= '0;
            wr_count <= '0;
            if (rst) pkt <= '0;
        end else begin
            if (busy) tmr <= tmr - 1'b1;
            if (done) exec_q <= 1'b0;
            if (accept) begin
                wr_count <= wr_count + 1'b1;
                tmr      <= TW'(BUSY_CYC);
                if (!skip) begin
                    pkt[idx] <= wdata;
                    if (idx == IDX_W'(PKT_BYTES - 1)) begin
                        idx    <= '0;
                        exec_q <= 1'b1;
                        tmr    <= TW'(EXEC_CYC);
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/result_buf.sv
module result_buf
    import disk_pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  pkt_bytes_t load_pkt,
    input  logic       rd_stb,
    output logic       pending,
    output logic [7:0] rd_byte
);
    pkt_bytes_t        res_q;
    logic [RIDX_W-1:0] ridx;

    assign pending = (ridx != RIDX_W'(PKT_BYTES));
    assign rd_byte = pending ? res_q[ridx[IDX_W-1:0]] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            res_q <= '0;
            ridx  <= RIDX_W'(PKT_BYTES);
        end else if (load) begin
            res_q <= load_pkt;
            ridx  <= '0;
        end else if (rd_stb && pending) begin
            ridx <= ridx + 1'b1;
        end
    end
endmodule

// File: rtl/chan_route.sv
module chan_route
    import disk_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [7:0]        wdata,
    input  logic              irq_pend,
    output logic [NUM_CH-1:0] dma_sel,
    output logic [NUM_CH-1:0] irq_out
);
    always_ff @(posedge clk) begin
        if (rst)         dma_sel <= '0;
        else if (wr_stb) dma_sel <= chan_decode(wdata);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_line
        assign irq_out[g] = dma_sel[g] & irq_pend;
    end
endmodule

// File: rtl/disk_cmd_port.sv
module disk_cmd_port
    import disk_pkt_pkg::*;
#(
    parameter int BUSY_CYC = 3,
    parameter int EXEC_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [2:0] dma_sel,
    output logic [2:0] irq_out
);
    logic             rd_acc, wr_acc;
    logic             clr, data_wr, data_rd, ack_rd, chsel_wr;
    logic             busy, done, res_pend, irq_pend;
    logic [CNT_W-1:0] wr_count;
    logic [7:0]       res_byte;
    pkt_bytes_t       cmd_pkt;

    assign rd_acc   = bus_sel && !bus_wr;
    assign wr_acc   = bus_sel && bus_wr;
    assign clr      = wr_acc && (bus_addr == OFS_RESET);
    assign data_wr  = wr_acc && (bus_addr == OFS_DATA);
    assign data_rd  = rd_acc && (bus_addr == OFS_DATA);
    assign ack_rd   = rd_acc && (bus_addr == OFS_ACK);
    assign chsel_wr = wr_acc && (bus_addr == OFS_CHSEL);

    pkt_collect #(.BUSY_CYC(BUSY_CYC), .EXEC_CYC(EXEC_CYC)) u_col (
        .clk(clk), .rst(rst), .clr(clr), .wr_stb(data_wr), .wdata(bus_wdata),
        .busy(busy), .wr_count(wr_count), .done(done), .pkt(cmd_pkt)
    );

    result_buf u_res (
        .clk(clk), .rst(rst), .clr(clr), .load(done), .load_pkt(run_cmd(cmd_pkt)),
        .rd_stb(data_rd), .pending(res_pend), .rd_byte(res_byte)
    );

    chan_route u_chan (
        .clk(clk), .rst(rst), .wr_stb(chsel_wr), .wdata(bus_wdata),
        .irq_pend(irq_pend), .dma_sel(dma_sel), .irq_out(irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst || clr)  irq_pend <= 1'b0;
        else if (done)   irq_pend <= 1'b1;
        else if (ack_rd) irq_pend <= 1'b0;
    end

    always_comb begin
        case (bus_addr)
            OFS_STATUS: bus_rdata = status_byte(busy, res_pend, wr_count);
            OFS_DATA:   bus_rdata = res_byte;
            OFS_CLASS:  bus_rdata = {irq_pend, DEV_CLASS};
            default:    bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/disk_cmd_chk.sv
module disk_cmd_chk
    import disk_pkt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             busy,
    input logic [CNT_W-1:0] wr_count,
    input logic             done,
    input logic             res_pend,
    input logic             irq_pend,
    input logic [2:0]       dma_sel,
    input logic [2:0]       irq_out
);
    logic dwr, rst_wr, ack;
    assign dwr    = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign rst_wr = bus_sel && bus_wr && (bus_addr == OFS_RESET);
    assign ack    = bus_sel && !bus_wr && (bus_addr == OFS_ACK);

    // R11
    one_channel_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dma_sel));
    // R11
    irq_routing_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_out != 3'b000) |-> (irq_pend && irq_out == dma_sel));
    // R13
    port_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rst_wr |=> (wr_count == '0 && !res_pend && !irq_pend && !busy));
    // R2
    busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && !busy) |=> busy);
    // R2
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && busy) |=> $stable(wr_count));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && !busy) |=> (wr_count == $past(wr_count) + 4'd1));
    // R4
    done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !rst_wr) |=> (irq_pend && res_pend && !busy));
    // R10
    ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !done) |=> !irq_pend);
endmodule

bind disk_cmd_port disk_cmd_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .busy(busy), .wr_count(wr_count), .done(done), .res_pend(res_pend),
    .irq_pend(irq_pend), .dma_sel(dma_sel), .irq_out(irq_out)
);

// File: tb/tb_disk_cmd_port.sv
module tb_disk_cmd_port;
    localparam int BUSY = 3;
    localparam int EXEC = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] dma_sel, irq_out;

    int n_chk = 0, n_fail = 0;

    disk_cmd_port #(.BUSY_CYC(BUSY), .EXEC_CYC(EXEC)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_sel(dma_sel), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_cmd [8];
    logic [7:0] m_res [$];
    int         m_idx = 0, m_cnt = 0, m_bl = 0;
    bit         m_exec = 0, m_irq = 0;
    logic [2:0] m_sel = 3'b000;

    always @(posedge clk) begin
        bit         done_now, busy_now;
        logic [15:0] cy;
        done_now = m_exec && (m_bl == 1);
        busy_now = (m_bl != 0);
        if (rst) begin
            m_idx = 0; m_cnt = 0; m_bl = 0; m_exec = 0; m_irq = 0; m_sel = 3'b000;
            m_res.delete();
        end else if (bus_sel && bus_wr && bus_addr == 8'h08) begin
            m_idx = 0; m_cnt = 0; m_bl = 0; m_exec = 0; m_irq = 0;
            m_res.delete();
        end else begin
            if (m_bl > 0) m_bl--;
            if (done_now) begin
                m_exec = 0; m_irq = 1; m_res.delete();
                case (m_cmd[0])
                    8'hC0, 8'hC1, 8'hC2, 8'hC9: begin
                        cy = {m_cmd[3], m_cmd[2]} + 16'd1;
                        m_res = '{m_cmd[0], 8'h80, cy[7:0], cy[15:8],
                                  m_cmd[4], m_cmd[5], m_cmd[6], m_cmd[7]};
                    end
                    8'hF4, 8'hF5:
                        m_res = '{m_cmd[0], 8'h80, 8'h00, 8'h00,
                                  m_cmd[4], m_cmd[5], m_cmd[6], m_cmd[7]};
                    default:
                        m_res = '{8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
                endcase
            end else begin
                if (bus_sel && !bus_wr && bus_addr == 8'h04) m_irq = 0;
                if (bus_sel && !bus_wr && bus_addr == 8'h02 && m_res.size() > 0)
                    void'(m_res.pop_front());
            end
            if (bus_sel && bus_wr && bus_addr == 8'h02 && !busy_now) begin
                m_cnt = (m_cnt + 1) % 16;
                m_bl  = BUSY;
                if (!(m_idx == 0 && bus_wdata == 8'hFF)) begin
                    m_cmd[m_idx] = bus_wdata;
                    if (m_idx == 7) begin m_idx = 0; m_exec = 1; m_bl = EXEC; end
                    else m_idx++;
                end
            end
            if (bus_sel && bus_wr && bus_addr == 8'h06)
                m_sel = (bus_wdata == 8'h02) ? 3'b001 : (bus_wdata == 8'h04) ? 3'b010 :
                        (bus_wdata == 8'h08) ? 3'b100 : 3'b000;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [7:0] e;
        if (!rst) begin
            chk("R11 dma_sel", {5'd0, dma_sel}, {5'd0, m_sel});
            chk("R11 irq_out", {5'd0, irq_out}, {5'd0, (m_irq ? m_sel : 3'b000)});
            case (bus_addr)
                8'h00: begin
                    e = {4'(m_cnt), 1'b0, (m_res.size() != 0), 1'b0, (m_bl != 0)};
                    chk("R1 status model", bus_rdata, e);
                end
                8'h02: chk("R5 data model", bus_rdata, (m_res.size() != 0) ? m_res[0] : 8'h00);
                8'hFE: chk("R12 class model", bus_rdata, {m_irq, 7'h01});
                default: ;
            endcase
        end
    end

    task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_port(input logic [7:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_addr = a;
        @(negedge clk); v = bus_rdata;
    endtask

    task automatic wait_ready();
        bus_addr = 8'h00;
        @(negedge clk);
        while (bus_rdata[0]) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d);
        wait_ready();
        wr_port(8'h02, d);
    endtask

    task automatic send_pkt(input logic [7:0] p [8]);
        for (int i = 0; i < 8; i++) send_byte(p[i]);
        wait_ready();
    endtask

    task automatic read_res(input string req, input logic [7:0] exp [8]);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_port(8'h02, v);
            chk(req, v, exp[i]);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual %h expected %h", 8'h01, 8'h00);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        peek(8'h00, v); chk("R1 reset status", v, 8'h00);
        peek(8'hFE, v); chk("R12 reset class", v, 8'h01);
        chk("R11 reset irq_out", {5'd0, irq_out}, 8'h00);

        wr_port(8'h06, 8'h04);
        chk("R11 select ch2", {5'd0, dma_sel}, 8'h02);

        // R6 read command, cylinder incremented
        send_pkt('{8'hC0, 8'h00, 8'h12, 8'h00, 8'h03, 8'h05, 8'h02, 8'h00});
        peek(8'h00, v); chk("R3 R4 status after packet", v, 8'h84);
        peek(8'hFE, v); chk("R12 class interrupting", v, 8'h81);
        chk("R4 R11 irq on line 2", {5'd0, irq_out}, 8'h02);
        read_res("R6 result", '{8'hC0, 8'h80, 8'h13, 8'h00, 8'h03, 8'h05, 8'h02, 8'h00});
        peek(8'h00, v); chk("R5 pending cleared", v, 8'h80);
        rd_port(8'h02, v); chk("R5 empty read", v, 8'h00);
        rd_port(8'h04, v);
        peek(8'hFE, v); chk("R10 ack clears", v, 8'h01);

        // R7 system track write: cylinder ignored; counter wraps to 0 (R3)
        send_pkt('{8'hF5, 8'h00, 8'h34, 8'h12, 8'h01, 8'h02, 8'h01, 8'h00});
        peek(8'h00, v); chk("R3 counter wrap", v, 8'h04);
        read_res("R7 result", '{8'hF5, 8'h80, 8'h00, 8'h00, 8'h01, 8'h02, 8'h01, 8'h00});

        // R8 unknown command
        send_pkt('{8'h12, 8'h00, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99});
        read_res("R8 result", '{8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});

        // R2 write during busy is dropped
        wait_ready();
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h02; bus_wdata = 8'hC0;
        @(posedge clk); #1;
        bus_wdata = 8'h55;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        wait_ready();
        peek(8'h00, v); chk("R2 busy write not counted", v, 8'h90);
        for (int i = 0; i < 7; i++) begin
            logic [7:0] rest [7];
            rest = '{8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00};
            send_byte(rest[i]);
        end
        wait_ready();
        read_res("R2 packet intact", '{8'hC0, 8'h80, 8'h11, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00});

        // R9 leading FFh
        send_byte(8'hFF);
        send_pkt('{8'hC2, 8'h00, 8'hFF, 8'h00, 8'h07, 8'h08, 8'h03, 8'h00});
        peek(8'h00, v); chk("R9 FF counted", v, 8'h94);
        read_res("R9 result", '{8'hC2, 8'h80, 8'h00, 8'h01, 8'h07, 8'h08, 8'h03, 8'h00});

        // R10 ack in the completion cycle
        rd_port(8'h04, v);
        peek(8'hFE, v); chk("R10 cleared before race", v, 8'h01);
        for (int i = 0; i < 7; i++) send_byte(8'hC1);
        wait_ready();
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h02; bus_wdata = 8'h00;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (EXEC - 1) @(posedge clk);
        #1 bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h04;
        @(posedge clk); #1 bus_sel = 1'b0;
        peek(8'hFE, v); chk("R10 completion wins over ack", v, 8'h81);

        // R13 reset port mid-packet
        send_byte(8'hC0); send_byte(8'h00); send_byte(8'h05);
        wait_ready();
        wr_port(8'h08, 8'h00);
        peek(8'h00, v); chk("R13 status cleared", v, 8'h00);
        peek(8'hFE, v); chk("R13 interrupt cleared", v, 8'h01);
        chk("R13 channel kept", {5'd0, dma_sel}, 8'h02);
        send_pkt('{8'hC1, 8'h00, 8'h00, 8'h00, 8'h02, 8'h03, 8'h04, 8'h00});
        read_res("R13 fresh packet", '{8'hC1, 8'h80, 8'h01, 8'h00, 8'h02, 8'h03, 8'h04, 8'h00});

        // R11 channel choices with interrupt pending
        wr_port(8'h06, 8'h08);
        chk("R11 ch3 sel", {5'd0, dma_sel}, 8'h04);
        chk("R11 ch3 irq", {5'd0, irq_out}, 8'h04);
        wr_port(8'h06, 8'h00);
        chk("R11 none", {5'd0, irq_out}, 8'h00);
        wr_port(8'h06, 8'h03);
        chk("R11 invalid value", {5'd0, dma_sel}, 8'h00);
        wr_port(8'h06, 8'h02);
        chk("R11 ch1 irq", {5'd0, irq_out}, 8'h01);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule